// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps one status machine for every hardware thread of an instruction fetch stage and advances it each clock from the control traffic that later pipeline stages send back. For each thread it remembers which of four downstream stages has asked fetch to hold off. It applies squash requests from commit and from decode in a fixed order of precedence, and it follows the thread through instruction cache request, retry and response events. A thread that is waiting on the cache is never pushed into the stalled state by a downstream hold.

Each thread's status is visible at the outputs. A change flag says that some rule wrote a thread's status in the previous cycle. An activity flag tells the surrounding core whether the fetch stage has useful work. A per-thread enable selects which threads take part. A disabled thread is frozen.

The status values are Running, Idle, Squashing, Blocked, FillDone (cache data has arrived and is about to be consumed), WaitResp (a cache request is outstanding), WaitRetry (the cache refused a request), TrapPending and QuiescePending. The named transitions are as follows:
- commit-squash: any status to Squashing.
- squash-hold: any status to Squashing.
- decode-squash: any status other than Squashing to Squashing.
- stall: any status other than WaitResp and WaitRetry to Blocked.
- recover: Blocked or Squashing to Running.
- issue: Running or WaitRetry to WaitResp.
- refuse: Running to WaitRetry.
- fill: WaitResp to FillDone, or to Blocked if the thread is stalled.
- consume: FillDone to Running.

Idle, TrapPending and QuiescePending are held until a squash or a stall rewrites them.

Top module: `fetch_status_ctrl`

## Requirements
- R1: While rst_n is low, every thread reads Running (code 0), every stall bit is clear and state_changed is 0.
- R2: Each thread has one sticky stall bit per downstream stage, at index k of stage_block/stage_unblock. A block pulse sets the bit, an unblock pulse clears it, and the bit keeps its value in between. A block pulse and an unblock pulse for the same bit never arrive in the same cycle.
- R3: A thread counts as stalled in a cycle when ctx_stall is high or any of its stall bits is set. The stall bits used for this test already include that cycle's pulses.
- R4: An enabled thread with commit_squash high reads Squashing (code 2) one cycle later, from any status, including WaitResp (code 5). This rule takes precedence over every other rule.
- R5: With commit_squash low, commit_squash_hold high makes the thread read Squashing one cycle later.
- R6: decode_squash moves a thread to Squashing only if the thread is not already Squashing. If it is already Squashing, the lower-precedence rules decide the next status.
- R7: If no squash applies, a stalled thread moves to Blocked (code 3), unless it is in WaitResp (5) or WaitRetry (6), where it stays.
- R8: If no squash or stall applies, a thread in Blocked or Squashing returns to Running.
- R9: Otherwise the cache events decide the next status:
  - From Running, cache_retry moves the thread to WaitRetry. If cache_retry is low, cache_req moves it to WaitResp.
  - From WaitRetry, cache_req moves the thread to WaitResp.
  - From WaitResp, cache_resp moves the thread to FillDone (code 4), or to Blocked if the thread is stalled.
  - FillDone moves to Running on the following cycle.
- R10: stage_active is high exactly when some enabled thread currently reads Running, Squashing or FillDone.
- R11: A thread whose thread_en bit is low keeps its status and its stall bits, whatever its inputs carry.
- R12: state_changed is high in the cycle after any enabled thread's status was written by a rule, including when the same value is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_en | input | NUM_THREADS | Thread takes part this cycle |
| stage_block | input | NUM_THREADS x NUM_STAGES | Per-stage hold request pulses |
| stage_unblock | input | NUM_THREADS x NUM_STAGES | Per-stage hold release pulses |
| ctx_stall | input | 1 | Global stall while a context switch is in progress |
| commit_squash | input | NUM_THREADS | Squash from commit |
| commit_squash_hold | input | NUM_THREADS | Commit is still squashing |
| decode_squash | input | NUM_THREADS | Squash from decode |
| cache_req | input | NUM_THREADS | A cache line request was issued |
| cache_retry | input | NUM_THREADS | The cache refused the request |
| cache_resp | input | NUM_THREADS | A cache response was accepted |
| thread_state | output | NUM_THREADS x 4 | Registered status code per thread |
| state_changed | output | 1 | Some status was written in the previous cycle |
| stage_active | output | 1 | The fetch stage has useful work |

## Verification
All inputs are sampled at one clock edge. Status codes and state_changed are registered, so they show the effect of a stimulus exactly one cycle later. stage_active is a combinational decode of those registers and the current enable, so it follows in the same sample. The bench drives each stimulus 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge. Both its directed expectations and its cycle-by-cycle reference model are evaluated at that single point.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [3:0] {
        FS_RUN        = 4'd0,
        FS_IDLE       = 4'd1,
        FS_SQUASH     = 4'd2,
        FS_BLOCKED    = 4'd3,
        FS_FILL_DONE  = 4'd4,
        FS_WAIT_RESP  = 4'd5,
        FS_WAIT_RETRY = 4'd6,
        FS_TRAP       = 4'd7,
        FS_QUIESCE    = 4'd8
    } fstate_e;

    localparam int FS_W = 4;

    // Status values in which the stage has useful work.
    function automatic logic is_live(input logic [FS_W-1:0] s);
        return (s == FS_RUN) || (s == FS_SQUASH) || (s == FS_FILL_DONE);
    endfunction

    // Status values protected from a downstream stall.
    function automatic logic is_cache_wait(input logic [FS_W-1:0] s);
        return (s == FS_WAIT_RESP) || (s == FS_WAIT_RETRY);
    endfunction

endpackage

// File: rtl/fsc_stall_track.sv
module fsc_stall_track #(
    parameter int NUM_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [NUM_STAGES-1:0] blk,
    input  logic [NUM_STAGES-1:0] unblk,
    input  logic                  ctx_stall,
    output logic [NUM_STAGES-1:0] bits,
    output logic                  stalled
);

    logic [NUM_STAGES-1:0] bits_nxt;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        always_comb begin
            if (unblk[k])
                bits_nxt[k] = 1'b0;
            else if (blk[k])
                bits_nxt[k] = 1'b1;
            else
                bits_nxt[k] = bits[k];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[k] <= 1'b0;
            else if (en)
                bits[k] <= bits_nxt[k];
        end
    end

    // The stall test sees this cycle's pulses.
    assign stalled = ctx_stall | (|bits_nxt);

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            stalled,
    input  logic            sq_commit,
    input  logic            sq_hold,
    input  logic            sq_decode,
    input  logic            req,
    input  logic            retry,
    input  logic            resp,
    output logic [FS_W-1:0] state_o,
    output logic            wrote
);

    fstate_e cur_q, nxt;
    logic    wr;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= FS_RUN;
        else if (en)
            cur_q <= nxt;
    end

    // Next-state rules in precedence order.
    always_comb begin
        nxt = cur_q;
        wr  = 1'b0;
        if (sq_commit) begin
            nxt = FS_SQUASH;
            wr  = 1'b1;
        end else if (sq_hold) begin
            nxt = FS_SQUASH;
            wr  = 1'b1;
        end else if (sq_decode && cur_q != FS_SQUASH) begin
            nxt = FS_SQUASH;
            wr  = 1'b1;
        end else if (stalled && !is_cache_wait(cur_q)) begin
            nxt = FS_BLOCKED;
            wr  = 1'b1;
        end else if (cur_q == FS_BLOCKED || cur_q == FS_SQUASH) begin
            nxt = FS_RUN;
            wr  = 1'b1;
        end else begin
            unique case (cur_q)
                FS_WAIT_RESP: begin
                    if (resp) begin
                        nxt = stalled ? FS_BLOCKED : FS_FILL_DONE;
                        wr  = 1'b1;
                    end
                end
                FS_FILL_DONE: begin
                    nxt = FS_RUN;
                    wr  = 1'b1;
                end
                FS_RUN: begin
                    if (retry) begin
                        nxt = FS_WAIT_RETRY;
                        wr  = 1'b1;
                    end else if (req) begin
                        nxt = FS_WAIT_RESP;
                        wr  = 1'b1;
                    end
                end
                FS_WAIT_RETRY: begin
                    if (req) begin
                        nxt = FS_WAIT_RESP;
                        wr  = 1'b1;
                    end
                end
                default: begin
                    nxt = cur_q;
                    wr  = 1'b0;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        state_o = cur_q;
        wrote   = en & wr;
    end

endmodule

// File: rtl/fsc_activity.sv
module fsc_activity
    import fsc_pkg::*;
#(
    parameter int NUM_THREADS = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_THREADS-1:0]            en,
    input  logic [NUM_THREADS-1:0][FS_W-1:0]  states,
    input  logic [NUM_THREADS-1:0]            wrote,
    output logic                              changed,
    output logic                              active
);

    logic [NUM_THREADS-1:0] live;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_live
        assign live[t] = en[t] & is_live(states[t]);
    end

    assign active = |live;

    always_ff @(posedge clk) begin
        if (!rst_n)
            changed <= 1'b0;
        else
            changed <= |wrote;
    end

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int NUM_STAGES  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_THREADS-1:0]                 thread_en,
    input  logic [NUM_THREADS-1:0][NUM_STAGES-1:0] stage_block,
    input  logic [NUM_THREADS-1:0][NUM_STAGES-1:0] stage_unblock,
    input  logic                                   ctx_stall,
    input  logic [NUM_THREADS-1:0]                 commit_squash,
    input  logic [NUM_THREADS-1:0]                 commit_squash_hold,
    input  logic [NUM_THREADS-1:0]                 decode_squash,
    input  logic [NUM_THREADS-1:0]                 cache_req,
    input  logic [NUM_THREADS-1:0]                 cache_retry,
    input  logic [NUM_THREADS-1:0]                 cache_resp,
    output logic [NUM_THREADS-1:0][3:0]            thread_state,
    output logic                                   state_changed,
    output logic                                   stage_active
);

    logic [NUM_THREADS-1:0][NUM_STAGES-1:0] stall_bits;
    logic [NUM_THREADS-1:0]                 stalled;
    logic [NUM_THREADS-1:0]                 wrote;
    logic [NUM_THREADS-1:0][FS_W-1:0]       st;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        fsc_stall_track #(.NUM_STAGES(NUM_STAGES)) u_stall (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (thread_en[t]),
            .blk       (stage_block[t]),
            .unblk     (stage_unblock[t]),
            .ctx_stall (ctx_stall),
            .bits      (stall_bits[t]),
            .stalled   (stalled[t])
        );

        fsc_thread_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (thread_en[t]),
            .stalled   (stalled[t]),
            .sq_commit (commit_squash[t]),
            .sq_hold   (commit_squash_hold[t]),
            .sq_decode (decode_squash[t]),
            .req       (cache_req[t]),
            .retry     (cache_retry[t]),
            .resp      (cache_resp[t]),
            .state_o   (st[t]),
            .wrote     (wrote[t])
        );

        assign thread_state[t] = st[t];
    end

    fsc_activity #(.NUM_THREADS(NUM_THREADS)) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (thread_en),
        .states  (st),
        .wrote   (wrote),
        .changed (state_changed),
        .active  (stage_active)
    );

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int NUM_THREADS = 2,
    parameter int NUM_STAGES  = 4
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic [NUM_THREADS-1:0]                 thread_en,
    input logic [NUM_THREADS-1:0][NUM_STAGES-1:0] stage_block,
    input logic [NUM_THREADS-1:0][NUM_STAGES-1:0] stage_unblock,
    input logic [NUM_THREADS-1:0]                 commit_squash,
    input logic [NUM_THREADS-1:0]                 commit_squash_hold,
    input logic [NUM_THREADS-1:0][3:0]            thread_state,
    input logic [NUM_THREADS-1:0][NUM_STAGES-1:0] stall_bits,
    input logic                                   state_changed,
    input logic                                   stage_active
);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
        // R2
        pulse_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_block[t] & stage_unblock[t]) == '0);

        for (genvar k = 0; k < NUM_STAGES; k++) begin : g_k
            // R2
            sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                thread_en[t] && stage_block[t][k] |=> stall_bits[t][k]);
            // R2
            sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                thread_en[t] && stage_unblock[t][k] |=> !stall_bits[t][k]);
        end

        // R4
        commit_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
            thread_en[t] && commit_squash[t] |=> thread_state[t] == 4'd2);

        // R5
        squash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            thread_en[t] && commit_squash_hold[t] |=> thread_state[t] == 4'd2);

        // R11
        frozen_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !thread_en[t] |=> $stable(thread_state[t]) && $stable(stall_bits[t]));
    end

    // R12
    change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thread_state != $past(thread_state) |-> state_changed);

    // R10
    no_thread_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thread_en == '0 |-> !stage_active);

endmodule

bind fetch_status_ctrl fsc_checker #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_STAGES  (NUM_STAGES)
) u_fsc_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .thread_en          (thread_en),
    .stage_block        (stage_block),
    .stage_unblock      (stage_unblock),
    .commit_squash      (commit_squash),
    .commit_squash_hold (commit_squash_hold),
    .thread_state       (thread_state),
    .stall_bits         (stall_bits),
    .state_changed      (state_changed),
    .stage_active       (stage_active)
);

// File: tb/fetch_status_ctrl_test.sv
`timescale 1ns/1ps
module fetch_status_ctrl_test;

    localparam int T = 2;
    localparam int S = 4;

    localparam logic [3:0] C_RUN = 4'd0, C_SQ = 4'd2, C_BLK = 4'd3,
                           C_FILL = 4'd4, C_WR = 4'd5, C_WRT = 4'd6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst_n;
    logic [T-1:0]        en;
    logic [T-1:0][S-1:0] blk, unblk;
    logic                ctx;
    logic [T-1:0]        csq, chold, dsq, creq, cretry, cresp;
    logic [T-1:0][3:0]   st;
    logic                chg, act;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [3:0]   m_st    [T];
    logic [S-1:0] m_stall [T];
    logic         m_chg;

    fetch_status_ctrl #(.NUM_THREADS(T), .NUM_STAGES(S)) uut (
        .clk(clk), .rst_n(rst_n), .thread_en(en),
        .stage_block(blk), .stage_unblock(unblk), .ctx_stall(ctx),
        .commit_squash(csq), .commit_squash_hold(chold), .decode_squash(dsq),
        .cache_req(creq), .cache_retry(cretry), .cache_resp(cresp),
        .thread_state(st), .state_changed(chg), .stage_active(act)
    );

    task automatic check(input string tag, input int got, input int exp, input string what);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic clear_in();
        blk = '0; unblk = '0; ctx = 1'b0;
        csq = '0; chold = '0; dsq = '0; creq = '0; cretry = '0; cresp = '0;
    endtask

    // Next status from the rules of the requirements.
    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic stl,
            input logic c, input logic h, input logic d, input logic rq,
            input logic rt, input logic rs, output logic w);
        w = 1'b1;
        if (c || h)                              return C_SQ;
        if (d && s != C_SQ)                      return C_SQ;
        if (stl && s != C_WR && s != C_WRT)      return C_BLK;
        if (s == C_BLK || s == C_SQ)             return C_RUN;
        if (s == C_WR && rs)                     return stl ? C_BLK : C_FILL;
        if (s == C_FILL)                         return C_RUN;
        if (s == C_RUN && rt)                    return C_WRT;
        if ((s == C_RUN || s == C_WRT) && rq)    return C_WR;
        w = 1'b0;
        return s;
    endfunction

    task automatic step(input string tag);
        logic nchg;
        logic expa;
        nchg = 1'b0;
        for (int t = 0; t < T; t++) begin
            if (en[t]) begin
                logic [S-1:0] nb;
                logic stl, w;
                nb = (m_stall[t] | blk[t]) & ~unblk[t];
                stl = ctx | (|nb);
                m_st[t] = ref_next(m_st[t], stl, csq[t], chold[t], dsq[t],
                                   creq[t], cretry[t], cresp[t], w);
                m_stall[t] = nb;
                nchg |= w;
            end
        end
        m_chg = nchg;
        @(posedge clk);
        #1;
        expa = 1'b0;
        for (int t = 0; t < T; t++) begin
            check(tag, st[t], m_st[t], $sformatf("thread %0d status", t));
            if (en[t] && (m_st[t] == C_RUN || m_st[t] == C_SQ || m_st[t] == C_FILL))
                expa = 1'b1;
        end
        check("R12", chg, m_chg, "state_changed");
        check("R10", act, expa, "stage_active");
        clear_in();
    endtask

    task automatic expect_st(input int t, input logic [3:0] v, input string tag);
        check(tag, st[t], v, $sformatf("directed thread %0d status", t));
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        en = '1;
        clear_in();
        for (int t = 0; t < T; t++) begin
            m_st[t] = C_RUN;
            m_stall[t] = '0;
        end
        m_chg = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int t = 0; t < T; t++) check("R1", st[t], C_RUN, "reset status");
        check("R1", chg, 0, "reset state_changed");
        check("R1", act, 1, "reset stage_active");
        rst_n = 1'b1;

        // R9 cache flow
        creq[0] = 1; step("R9"); expect_st(0, C_WR, "R9");
        cresp[0] = 1; step("R9"); expect_st(0, C_FILL, "R9");
        step("R9"); expect_st(0, C_RUN, "R9");
        cretry[0] = 1; creq[0] = 1; step("R9"); expect_st(0, C_WRT, "R9");
        creq[0] = 1; step("R9"); expect_st(0, C_WR, "R9");

        // R4 commit squash overrides an outstanding miss
        csq[0] = 1; cresp[0] = 1; dsq[0] = 1; step("R4"); expect_st(0, C_SQ, "R4");
        step("R8"); expect_st(0, C_RUN, "R8");

        // R5 continuing squash
        chold[0] = 1; step("R5"); expect_st(0, C_SQ, "R5");
        chold[0] = 1; step("R5"); expect_st(0, C_SQ, "R5");
        check("R12", chg, 1, "rewrite flagged");
        step("R8"); expect_st(0, C_RUN, "R8");

        // R6 decode squash ignored while squashing
        csq[0] = 1; step("R6");
        dsq[0] = 1; step("R6"); expect_st(0, C_RUN, "R6");
        dsq[0] = 1; step("R6"); expect_st(0, C_SQ, "R6");
        step("R8"); expect_st(0, C_RUN, "R8");

        // R2 sticky stall bit
        blk[0][2] = 1; step("R2"); expect_st(0, C_BLK, "R2");
        step("R2"); expect_st(0, C_BLK, "R2");
        step("R2"); expect_st(0, C_BLK, "R2");
        unblk[0][2] = 1; step("R2"); expect_st(0, C_RUN, "R2");

        // R3 context-switch stall
        ctx = 1; step("R3"); expect_st(0, C_BLK, "R3"); expect_st(1, C_BLK, "R3");
        step("R3"); expect_st(0, C_RUN, "R3"); expect_st(1, C_RUN, "R3");

        // R7 cache wait protected from stall
        creq[1] = 1; step("R7"); expect_st(1, C_WR, "R7");
        blk[1][0] = 1; step("R7"); expect_st(1, C_WR, "R7");
        cresp[1] = 1; step("R7"); expect_st(1, C_BLK, "R7");
        unblk[1][0] = 1; step("R7"); expect_st(1, C_RUN, "R7");

        // R10 activity decode
        creq = '1; step("R10"); check("R10", act, 0, "all waiting");
        cresp = '1; step("R10"); check("R10", act, 1, "fill done");
        step("R10");

        // R11 disabled thread frozen
        en = 2'b01;
        csq[1] = 1; blk[1][1] = 1; step("R11"); expect_st(1, C_RUN, "R11");
        en = 2'b11; step("R11"); expect_st(1, C_RUN, "R11");
        en = 2'b00; step("R10"); check("R10", act, 0, "no thread enabled");
        en = 2'b11; step("R10");

        // Sweep against the reference model
        for (int i = 0; i < 3000; i++) begin
            en = ($urandom % 8 == 0) ? T'($urandom) : '1;
            for (int t = 0; t < T; t++) begin
                for (int k = 0; k < S; k++) begin
                    blk[t][k]   = ($urandom % 10 == 0);
                    unblk[t][k] = ($urandom % 6 == 0) && !blk[t][k];
                end
                csq[t]    = ($urandom % 24 == 0);
                chold[t]  = ($urandom % 20 == 0);
                dsq[t]    = ($urandom % 12 == 0);
                creq[t]   = ($urandom % 3 == 0);
                cretry[t] = ($urandom % 6 == 0);
                cresp[t]  = ($urandom % 3 == 0);
            end
            ctx = ($urandom % 20 == 0);
            step("R9");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule